// File: doc/BRIEF.md
# Ripple-through bubble FIFO register

This block is a first-in-first-out buffer made of a chain of identical stages, sixteen four-bit words by default. Each stage holds one word and a valid marker. It has no read or write pointers. A stage that is empty and whose upstream neighbour is full copies that word on the next clock edge and sets its own marker. In the same edge the neighbour's marker clears. Words therefore ripple toward the output end and empty slots bubble back toward the input end, one stage per clock.

A producer writes with a shift-in strobe while the input-ready flag is high. A consumer reads the word on the data output with a shift-out strobe while the output-ready flag is high. Both flags come straight from the marker flops of the first and last stages. The data output is released to high impedance when the output enable is low.

Units can be chained to form a deeper buffer with no glue logic:
- an upstream unit's output-ready feeds the downstream unit's shift-in;
- the downstream unit's input-ready feeds the upstream unit's shift-out;
- the upstream data output feeds the downstream data input.

Top module: `bubble_fifo`

## Requirements
- R1: A synchronous active-high reset clears every marker, so on the cycle after a reset edge in_ready is 1 and out_ready is 0. Data contents are don't-care.
- R2: A shift_in pulse while in_ready is 1 loads din into the first stage and sets its marker, so in_ready is 0 in the following cycle.
- R3: On each rising edge, every empty stage whose upstream stage is full takes that word and the upstream marker clears. All moves are decided from the markers before the edge, so a word advances at most one stage per clock. A word written into an empty buffer of DEPTH stages raises out_ready DEPTH edges after its load edge, counting the load edge. in_ready returns to 1 one edge after the load.
- R4: in_ready is 1 exactly when the first stage is empty. With writes offered every cycle and no reads, the buffer fills to DEPTH words and in_ready then stays 0.
- R5: out_ready is 1 exactly when the last stage holds a word. While it is 1 and no read is made, it stays 1 and dout stays unchanged.
- R6: A shift_out pulse while out_ready is 1 removes the word in the last stage, so out_ready is 0 in the next cycle. The later words then advance with no other action.
- R7: A shift_in while in_ready is 0, or a shift_out while out_ready is 0, is ignored. No word is stored or lost, and the stored words are unchanged.
- R8: Words leave in the order they were accepted, with their values intact.
- R9: When out_en is 0, dout is released to high impedance. When out_en is 1, dout drives the last stage's word.
- R10: Two units chained through the ready and strobe pins behave exactly like a single buffer of 2*DEPTH stages.
- R11: A write and a read accepted on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stage moves happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all markers |
| shift_in | input | 1 | Write strobe, honoured only while in_ready is 1 |
| din | input | WIDTH | Word to write |
| in_ready | output | 1 | First stage empty; a write will be accepted |
| shift_out | input | 1 | Read strobe, honoured only while out_ready is 1 |
| out_en | input | 1 | 1 drives dout, 0 releases it to high impedance |
| dout | output | WIDTH | Word in the last stage |
| out_ready | output | 1 | Last stage holds a word |

## Verification
A write into the first stage and a read from the last stage can be accepted on the same edge. In that case the buffer loses its oldest word and gains a new one, while words in between are moving through interior stages. The bench provokes this with pseudo-random strobes whose write and read biases swap halfway, so the run passes through nearly full and nearly empty states. It judges the result against a behavioural queue model that tracks each word's position. The same stimulus drives a two-unit chain, which is compared against a model of twice the depth.

// File: rtl/bubble_fifo_pkg.sv
package bubble_fifo_pkg;
  localparam int DEF_WIDTH = 4;
  localparam int DEF_DEPTH = 16;
endpackage

// File: rtl/bubble_stage.sv
module bubble_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_full,
  input  logic [WIDTH-1:0] up_data,
  input  logic             down_take,
  output logic             full,
  output logic [WIDTH-1:0] data,
  output logic             take
);
  // An empty slot pulls the neighbour's word in.
  assign take = up_full & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else begin
      full <= take | (full & ~down_take);
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data <= up_data;
    end
  end

  AST_TAKE_LOADS: assert property (@(posedge clk) disable iff (rst)
    take |=> (full && data == $past(up_data))); // R3

  AST_GIVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (full && down_take) |=> !full); // R3

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (full && !down_take) |=> (full && $stable(data))); // R5
endmodule

// File: rtl/bubble_out_drv.sv
module bubble_out_drv #(
  parameter int WIDTH = 4
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] pin
);
  assign pin = oe ? word : {WIDTH{1'bz}};
endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo
  import bubble_fifo_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH,
  parameter int DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  input  logic             out_en,
  output logic [WIDTH-1:0] dout,
  output logic             out_ready
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] full_v;
  logic [DEPTH-1:0] take_v;
  logic [WIDTH-1:0] data_v [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic             up_full;
    logic [WIDTH-1:0] up_data;
    logic             down_take;

    if (i == 0) begin : g_head
      assign up_full = shift_in;
      assign up_data = din;
    end else begin : g_body
      assign up_full = full_v[i-1];
      assign up_data = data_v[i-1];
    end

    if (i == LAST) begin : g_tail
      assign down_take = shift_out;
    end else begin : g_inner
      assign down_take = take_v[i+1];
    end

    bubble_stage #(.WIDTH(WIDTH)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .up_full   (up_full),
      .up_data   (up_data),
      .down_take (down_take),
      .full      (full_v[i]),
      .data      (data_v[i]),
      .take      (take_v[i])
    );
  end

  assign in_ready  = ~full_v[0];
  assign out_ready = full_v[LAST];

  bubble_out_drv #(.WIDTH(WIDTH)) u_drv (
    .oe   (out_en),
    .word (data_v[LAST]),
    .pin  (dout)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (in_ready && !out_ready)); // R1

  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (shift_in && in_ready) |=> !in_ready); // R2

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (shift_in && !in_ready) |=> (in_ready || $stable(data_v[0]))); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !shift_out) |=> out_ready); // R5

  AST_READ_DROPS: assert property (@(posedge clk) disable iff (rst)
    (out_ready && shift_out) |=> !out_ready); // R6

  AST_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!out_ready && shift_out && !full_v[LAST-1]) |=> !out_ready); // R7
endmodule

// File: tb/bubble_fifo_bench.sv
module bubble_fifo_model #(
  parameter int N = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       rd,
  input  logic [3:0] wdata,
  output logic       exp_in_ready,
  output logic       exp_out_ready,
  output logic [3:0] exp_dout
);
  int         pos_q [$];
  logic [3:0] dat_q [$];
  int         old_q [$];

  initial begin
    exp_in_ready  = 1'b1;
    exp_out_ready = 1'b0;
    exp_dout      = 4'h0;
  end

  always @(posedge clk) begin
    int  n;
    bit  wr_ok;
    bit  rd_ok;
    if (rst) begin
      pos_q.delete();
      dat_q.delete();
    end else begin
      old_q = pos_q;
      n     = pos_q.size();
      wr_ok = (n == 0) || (old_q[n-1] != 0);
      rd_ok = (n > 0) && (old_q[0] == N - 1);
      for (int j = 0; j < n; j++) begin
        if (j == 0) begin
          if (old_q[0] < N - 1) pos_q[0] = old_q[0] + 1;
        end else if (old_q[j] + 1 < old_q[j-1]) begin
          pos_q[j] = old_q[j] + 1;
        end
      end
      if (rd && rd_ok) begin
        void'(pos_q.pop_front());
        void'(dat_q.pop_front());
      end
      if (wr && wr_ok) begin
        pos_q.push_back(0);
        dat_q.push_back(wdata);
      end
    end
    exp_in_ready  = (pos_q.size() == 0) || (pos_q[pos_q.size()-1] != 0);
    exp_out_ready = (pos_q.size() > 0) && (pos_q[0] == N - 1);
    exp_dout      = (pos_q.size() > 0) ? dat_q[0] : 4'h0;
  end
endmodule

module bubble_fifo_bench;
  localparam int W = 4;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         shift_in;
  logic         shift_out;
  logic         out_en;
  logic [W-1:0] din;
  wire  [W-1:0] dout;
  logic         in_ready;
  logic         out_ready;

  wire  [W-1:0] lo_dout;
  wire  [W-1:0] hi_dout;
  logic         lo_out_ready;
  logic         hi_in_ready;
  logic         c_in_ready;
  logic         c_out_ready;

  logic         e_in_ready, e_out_ready;
  logic [3:0]   e_dout;
  logic         ce_in_ready, ce_out_ready;
  logic [3:0]   ce_dout;

  int checks = 0;
  int errors = 0;
  int coinc  = 0;
  int cycles = 0;
  bit started = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  bubble_fifo #(.WIDTH(W), .DEPTH(D)) u_bubble_fifo (
    .clk(clk), .rst(rst), .shift_in(shift_in), .din(din), .in_ready(in_ready),
    .shift_out(shift_out), .out_en(out_en), .dout(dout), .out_ready(out_ready)
  );

  // R10: two units chained through ready/strobe pins
  bubble_fifo #(.WIDTH(W), .DEPTH(D)) u_casc_lo (
    .clk(clk), .rst(rst), .shift_in(shift_in), .din(din), .in_ready(c_in_ready),
    .shift_out(hi_in_ready), .out_en(1'b1), .dout(lo_dout), .out_ready(lo_out_ready)
  );
  bubble_fifo #(.WIDTH(W), .DEPTH(D)) u_casc_hi (
    .clk(clk), .rst(rst), .shift_in(lo_out_ready), .din(lo_dout), .in_ready(hi_in_ready),
    .shift_out(shift_out), .out_en(out_en), .dout(hi_dout), .out_ready(c_out_ready)
  );

  bubble_fifo_model #(.N(D)) u_model (
    .clk(clk), .rst(rst), .wr(shift_in), .rd(shift_out), .wdata(din),
    .exp_in_ready(e_in_ready), .exp_out_ready(e_out_ready), .exp_dout(e_dout)
  );
  bubble_fifo_model #(.N(2*D)) u_model_c (
    .clk(clk), .rst(rst), .wr(shift_in), .rd(shift_out), .wdata(din),
    .exp_in_ready(ce_in_ready), .exp_out_ready(ce_out_ready), .exp_dout(ce_dout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog expired", cycles, 100000);
      finish_run();
    end
  end

  // Per-cycle comparison against the behavioural models.
  always @(negedge clk) begin
    if (started) begin
      chk(in_ready === e_in_ready, "R4 in_ready", in_ready, e_in_ready);
      chk(out_ready === e_out_ready, "R5 out_ready", out_ready, e_out_ready);
      if (out_en && e_out_ready)
        chk(dout === e_dout, "R8 dout order", dout, e_dout);
      if (!out_en)
        chk((dout === 4'bzzzz) || (dout === 4'b0000), "R9 dout released", dout, 0);
      chk(c_in_ready === ce_in_ready, "R10 chain in_ready", c_in_ready, ce_in_ready);
      chk(c_out_ready === ce_out_ready, "R10 chain out_ready", c_out_ready, ce_out_ready);
      if (out_en && ce_out_ready)
        chk(hi_dout === ce_dout, "R10 chain dout", hi_dout, ce_dout);
      // R11: write and read both accepted on the coming edge
      if (!rst && shift_in && shift_out && e_in_ready && e_out_ready) coinc++;
    end
  end

  task automatic step(input bit w, input bit r, input logic [3:0] d, input bit oe);
    @(posedge clk);
    #2;
    shift_in  = w;
    shift_out = r;
    din       = d;
    out_en    = oe;
  endtask

  initial begin
    rst = 1'b1; shift_in = 1'b0; shift_out = 1'b0; out_en = 1'b1; din = '0;
    @(posedge clk);
    started = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b1 && out_ready === 1'b0, "R1 reset flags", {in_ready, out_ready}, 2'b10);
    @(posedge clk); #2 rst = 1'b0;

    // R3 latency through an empty buffer
    step(1, 0, 4'hA, 1);
    @(posedge clk); #2 shift_in = 1'b0;
    for (int i = 1; i <= D; i++) begin
      @(negedge clk);
      if (i == 1) chk(in_ready === 1'b0, "R2 in_ready after write", in_ready, 0);
      if (i == 2) chk(in_ready === 1'b1, "R3 slot bubbles back", in_ready, 1);
      if (i < D)  chk(out_ready === 1'b0, "R3 not yet at output", out_ready, 0);
      else        chk(out_ready === 1'b1 && dout === 4'hA, "R3 arrival after DEPTH edges",
                      {out_ready, dout}, {1'b1, 4'hA});
    end

    // R6 single read empties the output stage
    step(0, 1, 4'h0, 1);
    step(0, 0, 4'h0, 1);
    @(negedge clk);
    chk(out_ready === 1'b0, "R6 read clears out_ready", out_ready, 0);

    // R4 fill with no reads
    for (int i = 0; i < 70; i++) step(1, 0, 4'(i + 1), 1);
    @(negedge clk);
    chk(in_ready === 1'b0 && out_ready === 1'b1, "R4 buffer full", {in_ready, out_ready}, 2'b01);
    // R7 writes while full are ignored (model checks the drained order)
    for (int i = 0; i < 10; i++) step(1, 0, 4'hF, 1);
    @(negedge clk);
    chk(in_ready === 1'b0, "R7 full stays full", in_ready, 0);

    // Drain, then keep reading an empty buffer (R7)
    for (int i = 0; i < 90; i++) step(0, 1, 4'h0, 1);
    @(negedge clk);
    chk(out_ready === 1'b0 && in_ready === 1'b1, "R7 empty after drain", {in_ready, out_ready}, 2'b10);

    // R9 output enable
    step(1, 0, 4'h5, 1);
    step(0, 0, 4'h0, 1);
    for (int i = 0; i < 2 * D + 4; i++) step(0, 0, 4'h0, 1);
    step(0, 0, 4'h0, 0);
    @(negedge clk);
    chk((dout === 4'bzzzz) || (dout === 4'b0000), "R9 released while disabled", dout, 0);
    step(0, 0, 4'h0, 1);
    @(negedge clk);
    chk(dout === 4'h5, "R9 driven when enabled", dout, 5);

    // Pseudo-random traffic; biases swap halfway
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i == 2500) begin
        @(posedge clk); #2 rst = 1'b1; shift_in = 1'b0; shift_out = 1'b0;
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        chk(in_ready === 1'b1 && out_ready === 1'b0, "R1 mid-run reset", {in_ready, out_ready}, 2'b10);
      end
      if (i < 2000)
        step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[7:4], |lfsr[10:8]);
      else
        step(lfsr[0] & lfsr[1], lfsr[2] | lfsr[3], lfsr[7:4], |lfsr[10:8]);
    end
    step(0, 0, 4'h0, 1);
    @(negedge clk);
    chk(coinc > 0, "R11 same-edge write and read seen", coinc, 1);
    finish_run();
  end
endmodule